// File: doc/BRIEF.md
# Stage Register with Hold and Nop Injection

This block is the storage element placed between two stages of an instruction pipeline. Each rising clock edge it updates its bundle in one of three ways, chosen by two control inputs from the pipeline control logic. It loads the upstream bundle, keeps what it holds, or overwrites itself with a fixed no-operation bundle. The bundle has five fields: a status code, an instruction class code, two destination register identifiers and a generic payload. The payload width and the nop encoding are parameters. The register does not decide when to hold or inject. It only carries out the control it is given.

The nop bundle has the bubble status (0), the parameterised nop class code (default 1), both destination identifiers at the "no register" value (all ones, 0xF by default) and the nop payload (default 0). A bundle written this way moves down the pipeline as an ordinary no-operation and has no side effects. Raising hold and inject together is illegal. In that case the register keeps its contents and reports the clash for one cycle.

The control is a small state machine with two states. `ST_RUN` means the last edge had a legal control pair. `ST_FAULT` means the last edge saw hold and inject both high. The transitions are RUN→FAULT on a clash, FAULT→FAULT on a repeated clash, FAULT→RUN on a legal pair, RUN→RUN on a legal pair, and reset to RUN. Each edge is also decoded into one of four modes: PASS, KEEP, NOP and CLASH.

Top module: `pipe_stage_reg`

## Requirements
- R1: While reset is high at an edge, the outputs become the nop bundle after that edge and clash_o becomes 0, whatever hold_i, inject_i and the inputs are. The nop bundle is status 0, class NOP_CLASS (1), dst_e 0xF, dst_m 0xF and payload 0.
- R2: With hold_i=0 and inject_i=0 at an edge, every output field equals the matching input field after that edge.
- R3: With hold_i=1 and inject_i=0 at an edge, every output field keeps its value and the inputs have no effect.
- R4: With hold_i=0 and inject_i=1 at an edge, the outputs become the nop bundle of R1, whatever the inputs are.
- R5: With hold_i=1 and inject_i=1 at an edge, every output field keeps its value.
- R6: clash_o is 1 in the cycle after an edge where hold_i and inject_i were both 1, and 0 after any other edge.
- R7: After an injected nop, a following edge with hold_i=0 and inject_i=0 loads the upstream bundle again with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | Keep present contents |
| inject_i | input | 1 | Load the nop bundle |
| d_status | input | 3 | Incoming status code |
| d_class | input | CLASS_W | Incoming instruction class |
| d_dst_e | input | REG_W | Incoming first destination register id |
| d_dst_m | input | REG_W | Incoming second destination register id |
| d_payload | input | PAY_W | Incoming payload |
| q_status | output | 3 | Registered status code |
| q_class | output | CLASS_W | Registered instruction class |
| q_dst_e | output | REG_W | Registered first destination register id |
| q_dst_m | output | REG_W | Registered second destination register id |
| q_payload | output | PAY_W | Registered payload |
| clash_o | output | 1 | Hold and inject were both high at the last edge |

## Verification
The assertions check every cycle that a legal pair loads, keeps or injects exactly, that a clash leaves the bundle untouched, and that the clash flag follows the control pair one edge later. A reset check is included as well. The bench scenarios are needed for the rest. They show that an inject followed by a load restarts the flow at once (R7), that a long run of holds ignores changing inputs, that the nop fields carry their actual code values, and that reset wins over every control pair.

// File: rtl/pipe_stage_pkg.sv
package pipe_stage_pkg;

    localparam int STAT_W = 3;

    // Status codes carried in the bundle
    localparam logic [STAT_W-1:0] STS_BUBBLE = 3'd0;
    localparam logic [STAT_W-1:0] STS_OK     = 3'd1;
    localparam logic [STAT_W-1:0] STS_HALT   = 3'd2;
    localparam logic [STAT_W-1:0] STS_ADDR   = 3'd3;
    localparam logic [STAT_W-1:0] STS_INSN   = 3'd4;

    // Update mode decoded from the control pair each edge
    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_KEEP  = 2'd1,
        MODE_NOP   = 2'd2,
        MODE_CLASH = 2'd3
    } mode_e;

    // Control state: did the last edge see an illegal pair
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/pipe_stage_mode_dec.sv
module pipe_stage_mode_dec
    import pipe_stage_pkg::*;
(
    input  logic  hold,
    input  logic  inject,
    output mode_e mode
);

    always_comb begin
        unique case ({hold, inject})
            2'b00:   mode = MODE_PASS;
            2'b10:   mode = MODE_KEEP;
            2'b01:   mode = MODE_NOP;
            default: mode = MODE_CLASH;
        endcase
    end

endmodule

// File: rtl/pipe_stage_nop_gen.sv
module pipe_stage_nop_gen
    import pipe_stage_pkg::*;
#(
    parameter int                 CLASS_W     = 4,
    parameter int                 REG_W       = 4,
    parameter int                 PAY_W       = 32,
    parameter logic [CLASS_W-1:0] NOP_CLASS   = 1,
    parameter logic [REG_W-1:0]   REG_NONE    = '1,
    parameter logic [PAY_W-1:0]   NOP_PAYLOAD = '0,
    localparam int                BUN_W       = STAT_W + CLASS_W + 2*REG_W + PAY_W
) (
    output logic [BUN_W-1:0] nop_bundle
);

    // Field order: status, class, dst_e, dst_m, payload (MSB to LSB)
    assign nop_bundle = {STS_BUBBLE, NOP_CLASS, REG_NONE, REG_NONE, NOP_PAYLOAD};

endmodule

// File: rtl/pipe_stage_next_sel.sv
module pipe_stage_next_sel
    import pipe_stage_pkg::*;
#(
    parameter int BUN_W = 47
) (
    input  mode_e            mode,
    input  logic [BUN_W-1:0] cur,
    input  logic [BUN_W-1:0] din,
    input  logic [BUN_W-1:0] nop,
    output logic [BUN_W-1:0] nxt
);

    always_comb begin
        unique case (mode)
            MODE_PASS:  nxt = din;
            MODE_NOP:   nxt = nop;
            MODE_KEEP:  nxt = cur;
            MODE_CLASH: nxt = cur;
            default:    nxt = cur;
        endcase
    end

endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg
    import pipe_stage_pkg::*;
#(
    parameter int                 CLASS_W     = 4,
    parameter int                 REG_W       = 4,
    parameter int                 PAY_W       = 32,
    parameter logic [CLASS_W-1:0] NOP_CLASS   = 1,
    parameter logic [REG_W-1:0]   REG_NONE    = '1,
    parameter logic [PAY_W-1:0]   NOP_PAYLOAD = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold_i,
    input  logic               inject_i,
    input  logic [STAT_W-1:0]  d_status,
    input  logic [CLASS_W-1:0] d_class,
    input  logic [REG_W-1:0]   d_dst_e,
    input  logic [REG_W-1:0]   d_dst_m,
    input  logic [PAY_W-1:0]   d_payload,
    output logic [STAT_W-1:0]  q_status,
    output logic [CLASS_W-1:0] q_class,
    output logic [REG_W-1:0]   q_dst_e,
    output logic [REG_W-1:0]   q_dst_m,
    output logic [PAY_W-1:0]   q_payload,
    output logic               clash_o
);

    localparam int BUN_W = STAT_W + CLASS_W + 2*REG_W + PAY_W;

    mode_e            mode;
    ctl_state_e       state_q, state_d;
    logic [BUN_W-1:0] bundle_q, bundle_d, din_flat, nop_flat;

    assign din_flat = {d_status, d_class, d_dst_e, d_dst_m, d_payload};

    pipe_stage_mode_dec u_dec (
        .hold   (hold_i),
        .inject (inject_i),
        .mode   (mode)
    );

    pipe_stage_nop_gen #(
        .CLASS_W     (CLASS_W),
        .REG_W       (REG_W),
        .PAY_W       (PAY_W),
        .NOP_CLASS   (NOP_CLASS),
        .REG_NONE    (REG_NONE),
        .NOP_PAYLOAD (NOP_PAYLOAD)
    ) u_nop (
        .nop_bundle (nop_flat)
    );

    pipe_stage_next_sel #(
        .BUN_W (BUN_W)
    ) u_sel (
        .mode (mode),
        .cur  (bundle_q),
        .din  (din_flat),
        .nop  (nop_flat),
        .nxt  (bundle_d)
    );

    // Next-state logic for the control state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = (mode == MODE_CLASH) ? ST_FAULT : ST_RUN;
            ST_FAULT: state_d = (mode == MODE_CLASH) ? ST_FAULT : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // State and bundle registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            bundle_q <= nop_flat;
        end else begin
            state_q  <= state_d;
            bundle_q <= bundle_d;
        end
    end

    // Output process
    always_comb begin
        {q_status, q_class, q_dst_e, q_dst_m, q_payload} = bundle_q;
        unique case (state_q)
            ST_FAULT: clash_o = 1'b1;
            default:  clash_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pipe_stage_reg_chk.sv
module pipe_stage_reg_chk
    import pipe_stage_pkg::*;
#(
    parameter int                 CLASS_W     = 4,
    parameter int                 REG_W       = 4,
    parameter int                 PAY_W       = 32,
    parameter logic [CLASS_W-1:0] NOP_CLASS   = 1,
    parameter logic [REG_W-1:0]   REG_NONE    = '1,
    parameter logic [PAY_W-1:0]   NOP_PAYLOAD = '0
) (
    input logic               clk,
    input logic               rst,
    input logic               hold_i,
    input logic               inject_i,
    input logic [STAT_W-1:0]  d_status,
    input logic [CLASS_W-1:0] d_class,
    input logic [REG_W-1:0]   d_dst_e,
    input logic [REG_W-1:0]   d_dst_m,
    input logic [PAY_W-1:0]   d_payload,
    input logic [STAT_W-1:0]  q_status,
    input logic [CLASS_W-1:0] q_class,
    input logic [REG_W-1:0]   q_dst_e,
    input logic [REG_W-1:0]   q_dst_m,
    input logic [PAY_W-1:0]   q_payload,
    input logic               clash_o
);

    localparam int BUN_W = STAT_W + CLASS_W + 2*REG_W + PAY_W;
    localparam logic [BUN_W-1:0] NOP_B = {STS_BUBBLE, NOP_CLASS, REG_NONE, REG_NONE, NOP_PAYLOAD};

    logic [BUN_W-1:0] din_b, out_b;
    assign din_b = {d_status, d_class, d_dst_e, d_dst_m, d_payload};
    assign out_b = {q_status, q_class, q_dst_e, q_dst_m, q_payload};

    AST_RESET_NOP: assert property (@(posedge clk) rst |=> (out_b == NOP_B && !clash_o)); // R1
    AST_PASS_LOAD: assert property (@(posedge clk) disable iff (rst) (!hold_i && !inject_i) |=> out_b == $past(din_b)); // R2
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst) (hold_i && !inject_i) |=> $stable(out_b)); // R3
    AST_INJECT_NOP: assert property (@(posedge clk) disable iff (rst) (!hold_i && inject_i) |=> out_b == NOP_B); // R4
    AST_CLASH_KEEP: assert property (@(posedge clk) disable iff (rst) (hold_i && inject_i) |=> $stable(out_b)); // R5
    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (rst) (hold_i && inject_i) |=> clash_o); // R6
    AST_NO_CLASH_FLAG: assert property (@(posedge clk) disable iff (rst) !(hold_i && inject_i) |=> !clash_o); // R6

endmodule

bind pipe_stage_reg pipe_stage_reg_chk #(
    .CLASS_W     (CLASS_W),
    .REG_W       (REG_W),
    .PAY_W       (PAY_W),
    .NOP_CLASS   (NOP_CLASS),
    .REG_NONE    (REG_NONE),
    .NOP_PAYLOAD (NOP_PAYLOAD)
) chk_i (.*);

// File: tb/pipe_stage_reg_tb.sv
module pipe_stage_reg_tb_top;

    localparam int CW = 4;
    localparam int RW = 4;
    localparam int PW = 32;
    localparam int BW = 3 + CW + 2*RW + PW;
    // R1 nop bundle: status 0, class 1, dst_e F, dst_m F, payload 0
    localparam logic [BW-1:0] NOP_EXP = {3'd0, 4'h1, 4'hF, 4'hF, 32'h0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_i = 1'b0;
    logic inject_i = 1'b0;
    logic [2:0]    d_status = '0;
    logic [CW-1:0] d_class = '0;
    logic [RW-1:0] d_dst_e = '0;
    logic [RW-1:0] d_dst_m = '0;
    logic [PW-1:0] d_payload = '0;
    logic [2:0]    q_status;
    logic [CW-1:0] q_class;
    logic [RW-1:0] q_dst_e;
    logic [RW-1:0] q_dst_m;
    logic [PW-1:0] q_payload;
    logic          clash_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pipe_stage_reg dut_i (.*);

    function automatic logic [BW-1:0] outs();
        return {q_status, q_class, q_dst_e, q_dst_m, q_payload};
    endfunction

    task automatic check_b(input string req, input logic [BW-1:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s bundle act=%h exp=%h", req, outs(), exp);
        end
    endtask

    task automatic check_c(input string req, input logic exp);
        checks++;
        if (clash_o !== exp) begin
            errors++;
            $display("FAIL %s clash act=%b exp=%b", req, clash_o, exp);
        end
    endtask

    // Drive at negedge, one edge passes, caller checks at the next negedge
    task automatic cycle(input logic r, input logic h, input logic j, input logic [BW-1:0] b);
        rst = r; hold_i = h; inject_i = j;
        {d_status, d_class, d_dst_e, d_dst_m, d_payload} = b;
        @(negedge clk);
    endtask

    localparam logic [BW-1:0] BA = {3'd1, 4'h6, 4'h2, 4'h3, 32'hA5A5_0001};
    localparam logic [BW-1:0] BB = {3'd2, 4'h9, 4'h0, 4'hE, 32'h1234_5678};
    localparam logic [BW-1:0] BC = {3'd4, 4'hC, 4'h7, 4'h1, 32'hFFFF_FFFF};
    localparam logic [BW-1:0] BD = {3'd3, 4'h2, 4'h5, 4'h5, 32'h0BAD_F00D};

    task automatic t_reset();
        cycle(1'b1, 1'b1, 1'b1, BC);
        check_b("R1", NOP_EXP); check_c("R1", 1'b0);
        cycle(1'b1, 1'b0, 1'b0, BA);
        check_b("R1", NOP_EXP);
    endtask

    task automatic t_load();
        cycle(1'b0, 1'b0, 1'b0, BA); check_b("R2", BA); check_c("R6", 1'b0);
        cycle(1'b0, 1'b0, 1'b0, BB); check_b("R2", BB);
        cycle(1'b0, 1'b0, 1'b0, BC); check_b("R2", BC);
    endtask

    task automatic t_hold();
        cycle(1'b0, 1'b0, 1'b0, BD); check_b("R2", BD);
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 1'b1, 1'b0, (i == 1) ? BA : BB);
            check_b("R3", BD);
        end
        check_c("R6", 1'b0);
    endtask

    task automatic t_inject();
        cycle(1'b0, 1'b0, 1'b0, BA); check_b("R2", BA);
        cycle(1'b0, 1'b0, 1'b1, BC); check_b("R4", NOP_EXP);
        cycle(1'b0, 1'b0, 1'b1, BB); check_b("R4", NOP_EXP);
        cycle(1'b0, 1'b0, 1'b0, BD); check_b("R7", BD);
    endtask

    task automatic t_clash();
        cycle(1'b0, 1'b0, 1'b0, BB); check_b("R2", BB);
        cycle(1'b0, 1'b1, 1'b1, BC); check_b("R5", BB); check_c("R6", 1'b1);
        cycle(1'b0, 1'b1, 1'b1, BA); check_b("R5", BB); check_c("R6", 1'b1);
        cycle(1'b0, 1'b1, 1'b0, BA); check_b("R3", BB); check_c("R6", 1'b0);
        cycle(1'b0, 1'b1, 1'b1, BD); check_c("R6", 1'b1);
        cycle(1'b0, 1'b0, 1'b0, BD); check_b("R2", BD); check_c("R6", 1'b0);
    endtask

    task automatic t_reset_mid();
        cycle(1'b0, 1'b1, 1'b1, BA); check_c("R6", 1'b1);
        cycle(1'b1, 1'b0, 1'b0, BA); check_b("R1", NOP_EXP); check_c("R1", 1'b0);
        cycle(1'b0, 1'b0, 1'b0, BC); check_b("R2", BC);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_hold();
        t_inject();
        t_clash();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule